// File: doc/BRIEF.md
# SDRAM Row-Column Access Sequencer

This block sits between a simple host port and one four-bank SDRAM device. It turns each single-word read or write request into the command sequence the memory expects. It opens the row with a bank activate, then issues the column read or write. It closes the row either with the self-timed precharge flag on the column command or with an explicit precharge command. Between accesses it inserts periodic auto refresh commands.

The device mode (CAS latency 2 or 3, and whether bursts run in full-page form) is set by another block. This sequencer follows that mode through two level inputs, which must be held steady while an access is in progress. When full-page mode is active, a burst-stop command is issued on the cycle right after the column command, so each access still moves exactly one word.

All command, address and data-out pins come straight from flip-flops. Minimum gaps after activate, precharge and refresh are set by parameters and filled with NOP commands.

Top module: `sdram_seq`

## Requirements
- R1: While reset is asserted, the command pins carry NOP ({sel,row,col,wr} = 0,1,1,1), every data mask bit is high, ack is low and the data output enable is low.
- R2: An access issues ACTIVE (0,0,1,1) with the request bank on mem_bank and the row on mem_addr. It then issues READ (0,1,0,1) or WRITE (0,1,0,0) with the same bank and the column on mem_addr[8:0]. Write data is driven, with the output enable high and all mask bits low, only during the WRITE cycle.
- R3: The column command comes at least T_RCD clock cycles after the ACTIVE.
- R4: mem_addr[10] on the column command equals req_ap when full-page mode is off. If that bit is set, no PRECHARGE is issued for the access. Otherwise exactly one PRECHARGE (0,0,1,0) is issued, with mem_addr[10] low and the access bank on mem_bank. After a PRECHARGE, the next ACTIVE or REFRESH comes at least T_RP cycles later.
- R5: In full-page mode, every column command is followed in the next cycle by BURST STOP (0,1,1,0), mem_addr[10] is forced low, and the row is closed with an explicit PRECHARGE.
- R6: Read data is sampled from mem_dq_in 2 clock cycles (mode_lat3 = 0) or 3 clock cycles (mode_lat3 = 1) after the device registers READ. It is presented on rdata when ack is high.
- R7: A refresh becomes due every REF_INT cycles and is issued as AUTO REFRESH (0,0,0,1). After a REFRESH, no other command is issued for at least T_RFC cycles.
- R8: A due refresh wins over a waiting request in the idle state, but it never interrupts an access that has already started.
- R9: ack is a single-cycle pulse at the end of each access. req is held high until ack, and a request is not accepted in the cycle ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_lat3 | input | 1 | 1 selects CAS latency 3, 0 selects latency 2 |
| mode_fpage | input | 1 | Device runs full-page bursts; cut each one with burst stop |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 for write, 0 for read |
| req_ap | input | 1 | Close the row with self-timed precharge |
| req_bank | input | BANK_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| req_col | input | COL_W | Column of the access |
| req_wdata | input | DQ_W | Write data |
| ack | output | 1 | Access complete pulse |
| rdata | output | DQ_W | Read data, valid with ack after a read |
| cmd_sel_n | output | 1 | Command bit: chip select, active low |
| cmd_row_n | output | 1 | Command bit: row strobe, active low |
| cmd_col_n | output | 1 | Command bit: column strobe, active low |
| cmd_wr_n | output | 1 | Command bit: write enable, active low |
| mem_bank | output | BANK_W | Bank address |
| mem_addr | output | ROW_W | Row / column address, bit 10 is the precharge flag |
| mem_mask | output | DQ_W/8 | Byte data masks, high = masked |
| mem_dq_out | output | DQ_W | Write data to the device |
| mem_dq_oe | output | 1 | Output enable for mem_dq_out |
| mem_dq_in | input | DQ_W | Read data from the device |

## Verification
The bench builds the sequencer with T_RCD = 3, T_RP = 2, T_RFC = 5 and REF_INT = 64. The short refresh interval makes a refresh fall due during accesses many times within a few hundred cycles, so both the idle-state priority and the no-preemption rule get exercised. The unequal gap parameters let a swapped or shortened wait show up in the bench's command-gap monitor. Both latency settings and both row-closing methods are run with and without full-page mode, against a device model that presents read data only in the single cycle the chosen latency allows.

// File: rtl/sdram_seq.sv
`timescale 1ns/1ps
module sdram_seq #(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int DQ_W    = 16,
  parameter int AP_BIT  = 10,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RFC   = 7,
  parameter int REF_INT = 780
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_lat3,
  input  logic              mode_fpage,
  input  logic              req,
  input  logic              req_we,
  input  logic              req_ap,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              ack,
  output logic [DQ_W-1:0]   rdata,
  output logic              cmd_sel_n,
  output logic              cmd_row_n,
  output logic              cmd_col_n,
  output logic              cmd_wr_n,
  output logic [BANK_W-1:0] mem_bank,
  output logic [ROW_W-1:0]  mem_addr,
  output logic [DQ_W/8-1:0] mem_mask,
  output logic [DQ_W-1:0]   mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DQ_W-1:0]   mem_dq_in
);

  localparam int MASK_W = DQ_W / 8;
  localparam int CNT_W  = $clog2(T_RCD + T_RP + T_RFC + 4);
  localparam int REF_W  = $clog2(REF_INT + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_BST = 4'b0110;

  typedef enum logic [2:0] {S_IDLE, S_REF, S_ACT, S_RW, S_TAIL, S_PRE, S_PWAIT} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       cmd;
  logic             op_we, op_ap;
  logic [COL_W-1:0] op_col;
  logic [DQ_W-1:0]  op_wd;
  logic [REF_W-1:0] ref_cnt;
  logic             ref_pend;

  wire              ap_eff    = op_ap & ~mode_fpage;
  wire              issue_ref = (st == S_IDLE) && ref_pend;
  wire [CNT_W-1:0]  lat_m1    = mode_lat3 ? CNT_W'(2) : CNT_W'(1);

  assign {cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n} = cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt  <= REF_W'(REF_INT - 1);
      ref_pend <= 1'b0;
    end else begin
      if (issue_ref) ref_pend <= 1'b0;
      if (ref_cnt == '0) begin
        ref_cnt  <= REF_W'(REF_INT - 1);
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      cmd        <= C_NOP;
      mem_bank   <= '0;
      mem_addr   <= '0;
      mem_mask   <= {MASK_W{1'b1}};
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      ack        <= 1'b0;
      rdata      <= '0;
      op_we      <= 1'b0;
      op_ap      <= 1'b0;
      op_col     <= '0;
      op_wd      <= '0;
    end else begin
      cmd       <= C_NOP;
      mem_dq_oe <= 1'b0;
      ack       <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ref_pend) begin
            cmd <= C_REF;
            cnt <= CNT_W'(T_RFC - 1);
            st  <= S_REF;
          end else if (req && !ack) begin
            cmd      <= C_ACT;
            mem_bank <= req_bank;
            mem_addr <= req_row;
            op_we    <= req_we;
            op_ap    <= req_ap;
            op_col   <= req_col;
            op_wd    <= req_wdata;
            cnt      <= CNT_W'(T_RCD - 1);
            st       <= S_ACT;
          end
        end
        S_REF: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        S_ACT: begin
          if (cnt == '0) begin
            cmd              <= op_we ? C_WR : C_RD;
            mem_addr         <= ROW_W'(op_col);
            mem_addr[AP_BIT] <= ap_eff;
            mem_mask         <= '0;
            mem_dq_oe        <= op_we;
            mem_dq_out       <= op_wd;
            st               <= S_RW;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RW: begin
          if (mode_fpage) cmd <= C_BST;
          if (op_we) begin
            mem_mask <= {MASK_W{1'b1}};
            if (ap_eff) begin
              cnt <= CNT_W'(T_RP);
              st  <= S_PWAIT;
            end else begin
              st <= S_PRE;
            end
          end else begin
            cnt <= lat_m1;
            st  <= S_TAIL;
          end
        end
        S_TAIL: begin
          if (cnt == '0) begin
            rdata    <= mem_dq_in;
            mem_mask <= {MASK_W{1'b1}};
            if (ap_eff) begin
              cnt <= CNT_W'(T_RP);
              st  <= S_PWAIT;
            end else begin
              st <= S_PRE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_PRE: begin
          cmd              <= C_PRE;
          mem_addr[AP_BIT] <= 1'b0;
          cnt              <= CNT_W'(T_RP - 1);
          st               <= S_PWAIT;
        end
        S_PWAIT: begin
          if (cnt == '0) begin
            ack <= 1'b1;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdram_seq_chk.sv
`timescale 1ns/1ps
module sdram_seq_chk #(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RFC = 7
) (
  input logic clk,
  input logic rst_n,
  input logic sel_n,
  input logic row_n,
  input logic col_n,
  input logic wr_n,
  input logic ap_bit,
  input logic mask_any,
  input logic dq_oe,
  input logic ack,
  input logic fpage
);

  localparam int CW = $clog2(T_RCD + T_RP + T_RFC + 2) + 1;

  wire [3:0] c     = {sel_n, row_n, col_n, wr_n};
  wire       is_rw = (c == 4'b0101) || (c == 4'b0100);

  logic [CW-1:0] since_act, since_pre, since_ref;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (v == {CW{1'b1}}) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= {CW{1'b1}};
      since_pre <= {CW{1'b1}};
      since_ref <= {CW{1'b1}};
    end else begin
      since_act <= (c == 4'b0011) ? CW'(1) : bump(since_act);
      since_pre <= (c == 4'b0010) ? CW'(1) : bump(since_pre);
      since_ref <= (c == 4'b0001) ? CW'(1) : bump(since_ref);
    end
  end

  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> since_act >= CW'(T_RCD)); // R3
  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0011 || c == 4'b0001) |-> since_pre >= CW'(T_RP)); // R4
  AST_RFC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (c != 4'b0111) |-> since_ref >= CW'(T_RFC)); // R7
  AST_STOP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (fpage && is_rw) |=> (c == 4'b0110)); // R5
  AST_FPAGE_NO_AP: assert property (@(posedge clk) disable iff (!rst_n)
    (fpage && is_rw) |-> !ap_bit); // R5
  AST_WDATA_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (c == 4'b0100) && !mask_any); // R2
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R9

endmodule

bind sdram_seq sdram_seq_chk #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(cmd_sel_n), .row_n(cmd_row_n), .col_n(cmd_col_n),
  .wr_n(cmd_wr_n), .ap_bit(mem_addr[AP_BIT]), .mask_any(|mem_mask), .dq_oe(mem_dq_oe),
  .ack(ack), .fpage(mode_fpage));

// File: tb/sdram_seq_test.sv
`timescale 1ns/1ps
module sdram_seq_test;
  localparam int T_RCD = 3, T_RP = 2, T_RFC = 5, REF_INT = 64;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, BST = 4'b0110;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, mode_lat3 = 1'b0, mode_fpage = 1'b0;
  logic req = 1'b0, req_we = 1'b0, req_ap = 1'b0;
  logic [1:0] req_bank = '0;
  logic [12:0] req_row = '0;
  logic [8:0] req_col = '0;
  logic [15:0] req_wdata = '0;
  logic ack, cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n, mem_dq_oe;
  logic [15:0] rdata, mem_dq_out;
  logic [15:0] mem_dq_in = 16'hDEAD;
  logic [1:0] mem_bank, mem_mask;
  logic [12:0] mem_addr;

  sdram_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .REF_INT(REF_INT)) uut (
    .clk(clk), .rst_n(rst_n), .mode_lat3(mode_lat3), .mode_fpage(mode_fpage),
    .req(req), .req_we(req_we), .req_ap(req_ap), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
    .cmd_sel_n(cmd_sel_n), .cmd_row_n(cmd_row_n), .cmd_col_n(cmd_col_n), .cmd_wr_n(cmd_wr_n),
    .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_mask(mem_mask), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic we, ap, fp, l3;
    logic [1:0] bank;
    logic [12:0] row;
    logic [8:0] col;
    logic [15:0] data;
  } vec_t;

  localparam vec_t VECS [0:10] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 13'h0123, 9'h045, 16'hA5A5},
    '{1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 13'h0123, 9'h045, 16'hA5A5},
    '{1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 13'h0123, 9'h045, 16'hA5A5},
    '{1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 13'h1FFF, 9'h1FF, 16'h5A5A},
    '{1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 13'h1FFF, 9'h1FF, 16'h5A5A},
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 13'h0000, 9'h000, 16'h0F0F},
    '{1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 13'h0000, 9'h000, 16'h0F0F},
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 13'h00A5, 9'h0F0, 16'h8AF0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 13'h0123, 9'h044, 16'h4644},
    '{1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 13'h00A5, 9'h0F0, 16'h1234},
    '{1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 13'h00A5, 9'h0F0, 16'h1234}
  };

  // Device model and command monitor
  logic [15:0] mem [int];
  logic [12:0] open_row [0:3];
  logic [15:0] pd [0:4];
  logic        pv [0:4];
  int cyc = 0, last_act = -1000, last_pre = -1000, last_ref = -1000, ref_mark = 0;
  int pre_cnt = 0, ref_total = 0;
  logic [12:0] act_row; logic [1:0] act_ba, rw_ba; logic [8:0] rw_col;
  logic rw_a10 = 1'b0, rw_wr = 1'b0, prev_rw = 1'b0, prev_fp = 1'b0;

  initial for (int i = 0; i < 5; i++) begin pd[i] = '0; pv[i] = 1'b0; end

  always @(negedge clk) begin
    logic [3:0] c;
    int key;
    cyc++;
    for (int i = 0; i < 4; i++) begin pd[i] = pd[i+1]; pv[i] = pv[i+1]; end
    pv[4] = 1'b0;
    if (rst_n) begin
      c = {cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n};
      if (prev_rw && prev_fp) check(c == BST, "R5", "burst stop after column cmd", c, BST);
      prev_rw = 1'b0;
      if (c != NOP) check(cyc - last_ref >= T_RFC, "R7", "gap after refresh", cyc - last_ref, T_RFC);
      if (mem_dq_oe) check(c == WR, "R2", "data driven outside write", c, WR);
      case (c)
        ACT: begin
          open_row[mem_bank] = mem_addr; act_row = mem_addr; act_ba = mem_bank; last_act = cyc;
          check(cyc - last_pre >= T_RP, "R4", "precharge to activate gap", cyc - last_pre, T_RP);
          check(cyc - ref_mark <= REF_INT + 3, "R8", "refresh overdue at activate", cyc - ref_mark, REF_INT);
        end
        REF: begin
          check(cyc - last_pre >= T_RP, "R4", "precharge to refresh gap", cyc - last_pre, T_RP);
          last_ref = cyc; ref_mark = cyc; ref_total++;
        end
        PRE: begin
          pre_cnt++; last_pre = cyc;
          check(!mem_addr[10] && mem_bank == act_ba, "R4", "precharge bank/flag",
                {mem_addr[10], mem_bank}, {1'b0, act_ba});
        end
        RD, WR: begin
          check(cyc - last_act >= T_RCD, "R3", "activate to column gap", cyc - last_act, T_RCD);
          rw_col = mem_addr[8:0]; rw_ba = mem_bank; rw_a10 = mem_addr[10]; rw_wr = (c == WR);
          prev_rw = 1'b1; prev_fp = mode_fpage;
          key = int'({mem_bank, open_row[mem_bank], mem_addr[8:0]});
          if (c == WR) begin
            check(mem_dq_oe && mem_mask == 2'b00, "R2", "write data slot", {mem_dq_oe, mem_mask}, 3'b100);
            mem[key] = mem_dq_out;
          end else begin
            pd[mode_lat3 ? 3 : 2] = mem.exists(key) ? mem[key]
                                  : {mem_bank, open_row[mem_bank][4:0], mem_addr[8:0]};
            pv[mode_lat3 ? 3 : 2] = 1'b1;
          end
        end
        default: ;
      endcase
    end
    mem_dq_in = pv[0] ? pd[0] : 16'hDEAD;
  end

  task automatic do_access(input vec_t v);
    int p0;
    @(negedge clk);
    mode_lat3 = v.l3; mode_fpage = v.fp; req_we = v.we; req_ap = v.ap;
    req_bank = v.bank; req_row = v.row; req_col = v.col; req_wdata = v.data;
    req = 1'b1; p0 = pre_cnt;
    forever begin @(negedge clk); if (ack) break; end
    req = 1'b0;
    check(act_row == v.row && act_ba == v.bank, "R2", "activate row/bank", {act_ba, act_row}, {v.bank, v.row});
    check(rw_col == v.col && rw_ba == v.bank && rw_wr == v.we, "R2", "column command",
          {rw_wr, rw_ba, rw_col}, {v.we, v.bank, v.col});
    check(rw_a10 == (v.ap && !v.fp), v.fp ? "R5" : "R4", "precharge flag", rw_a10, v.ap && !v.fp);
    check(pre_cnt - p0 == ((v.ap && !v.fp) ? 0 : 1), "R4", "explicit precharge count",
          pre_cnt - p0, (v.ap && !v.fp) ? 0 : 1);
    if (!v.we) check(rdata == v.data, "R6", "read data at latency", rdata, v.data);
    @(negedge clk);
    check(!ack, "R9", "ack single pulse", ack, 0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    check({cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n} == NOP, "R1", "reset command",
          {cmd_sel_n, cmd_row_n, cmd_col_n, cmd_wr_n}, NOP);
    check(mem_mask == 2'b11 && !ack && !mem_dq_oe, "R1", "reset mask/ack/oe",
          {mem_mask, ack, mem_dq_oe}, 4'b1100);
    rst_n = 1'b1; ref_mark = cyc;

    foreach (VECS[i]) do_access(VECS[i]);

    r0 = ref_total;
    for (int k = 0; k < 10; k++) do_access(VECS[k % 2 == 0 ? 1 : 4]);
    check(ref_total - r0 >= 1, "R8", "refresh served under steady traffic", ref_total - r0, 1);

    @(negedge clk); r0 = ref_total;
    repeat (3 * REF_INT) @(negedge clk);
    check(ref_total - r0 >= 2 && ref_total - r0 <= 4, "R7", "refresh rate while idle", ref_total - r0, 3);

    finish_run();
  end
endmodule